// File: doc/BRIEF.md
# Lag-Correlation Coarse Frame Detector

This block watches a stream of complex baseband samples and recognises the start of a frame whose preamble is built from a short symbol repeated many times with a period of 32 samples. For every accepted sample it multiplies the new sample by the complex conjugate of the sample taken 32 samples earlier. It keeps the sum of these products over the most recent 32 samples, and beside it the sum of the power of the delayed samples over the same span. Both sums are kept by sliding accumulation: each new term is added and the term leaving the span is subtracted.

The correlation magnitude is approximated as |re| + |im|. It is compared against half the energy, and the half is taken with a shift, so no divider and no square root are needed. A sample passes when the magnitude is strictly greater than that half. A coarse frame start is declared only when the pass result has been 1 for 50 consecutive accepted samples. At that point a one-clock detect pulse fires and a locked flag rises. The flag stays high until a synchronous clear, which also empties all windows and the pass history. The magnitude and energy are exported for observation.

Top module: `preamble_autocorr_detect`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, `detect`, `locked`, `corr_mag` and `energy` are all 0.
- R2: With samples x[n] counted from the last reset or clear, with x = 0 before the first one, C = sum over k = 0..31 of x[n-k]·conj(x[n-k-32]). Here conj negates the imaginary part, so the term's real part is xr·dr + xi·di and its imaginary part is xi·dr − xr·di. The sum is exact for full-scale 12-bit inputs.
- R3: `energy` equals the sum over k = 0..31 of |x[n-k-32]|², the power of the delayed samples in the same window. It is never negative.
- R4: `corr_mag` equals |Re C| + |Im C|.
- R5: A sample passes only when `corr_mag` > floor(`energy`/2). Equality does not pass.
- R6: Each accepted sample shifts in the pass result produced by the previous accepted sample. Lock is declared when the last 50 shifted results are all 1. A single 0 restarts the count.
- R7: `detect` is high for exactly one clock at the moment of lock, and it does not fire again while `locked` is high.
- R8: `locked` stays high until `clr`. On `clr`, which has priority over `in_valid`, the delay line, the sums, the history, `locked` and `detect` are all zero on the next clock.
- R9: While `in_valid` is low and `clr` is low, no output changes, whatever the sample inputs carry.
- R10: `corr_mag` and `energy` reflect an accepted sample from the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all state and of the lock |
| in_valid | input | 1 | Sample strobe; all state advances only when high |
| in_re | input | SAMPLE_W | Signed in-phase sample |
| in_im | input | SAMPLE_W | Signed quadrature sample |
| detect | output | 1 | One-clock pulse at coarse frame detection |
| locked | output | 1 | Sticky detection flag |
| corr_mag | output | ACC_W | \|Re C\| + \|Im C\| of the window correlation |
| energy | output | ACC_W | Window energy of the delayed samples |

## Verification
A stale entry in one of the 32-deep delay lines corrupts `corr_mag` or `energy` exactly 32 accepted samples after it was written, when the entry leaves the window. The error does not clear after that, because the sliding sum keeps it. A history register that is too short or mis-shifted moves the `detect` pulse away from the 50th consecutive pass. The bench predicts that sample by recomputing both window sums directly from the raw sample history every cycle. A strobe-gating fault shows on the first idle cycle as a drift in the exported sums.

// File: rtl/acdet_pkg.sv
package acdet_pkg;

    // Accumulator width: product of two samples, a sum of two products,
    // then a full window of such terms.
    function automatic int acc_bits(input int sample_w, input int lag);
        return 2 * sample_w + 1 + $clog2(lag);
    endfunction

endpackage

// File: rtl/acdet_delay_line.sv
module acdet_delay_line #(
    parameter int W     = 24,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] tap;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.tap = '0;
        end else if (en) begin
            st_d.tap[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.tap[i] = st_q.tap[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.tap[DEPTH-1];

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(dout));

endmodule

// File: rtl/acdet_window_sum.sv
module acdet_window_sum #(
    parameter int W     = 30,
    parameter int DEPTH = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                clr,
    input  logic signed [W-1:0] term,
    output logic signed [W-1:0] sum
);

    typedef struct packed {
        logic signed [W-1:0] acc;
    } win_t;

    win_t st_d, st_q;
    logic [W-1:0] leaving;

    // Holds every term still inside the window; its output is the one leaving.
    acdet_delay_line #(.W(W), .DEPTH(DEPTH)) u_hist (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .clr  (clr),
        .din  (term),
        .dout (leaving)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (en) begin
            st_d.acc = st_q.acc + term - $signed(leaving);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum = st_q.acc;

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum == '0));

endmodule

// File: rtl/acdet_hold_qual.sv
module acdet_hold_qual #(
    parameter int HOLD = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic hit,
    output logic detect,
    output logic locked
);

    localparam int RUN_W = $clog2(HOLD + 1) + 1;

    typedef struct packed {
        logic [HOLD-1:0] hist;
        logic            det;
        logic            lock;
    } qual_t;

    qual_t st_d, st_q;
    logic [HOLD-1:0] hist_nx;

    always_comb begin
        st_d     = st_q;
        st_d.det = 1'b0;
        hist_nx  = {st_q.hist[HOLD-2:0], hit};
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            st_d.hist = hist_nx;
            if (&hist_nx && !st_q.lock) begin
                st_d.det  = 1'b1;
                st_d.lock = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign detect = st_q.det;
    assign locked = st_q.lock;

    // Consecutive-pass counter kept only for the run-length check below.
    logic [RUN_W-1:0] run_ct;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_ct <= '0;
        else if (clr)    run_ct <= '0;
        else if (en) begin
            if (!hit)                       run_ct <= '0;
            else if (run_ct < RUN_W'(HOLD)) run_ct <= run_ct + 1'b1;
        end
    end

    // R6
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detect |-> (run_ct == RUN_W'(HOLD)));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detect |=> !detect);

    // R7
    lock_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> detect);

    // R8
    sticky_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !clr) |=> locked);

endmodule

// File: rtl/preamble_autocorr_detect.sv
module preamble_autocorr_detect
    import acdet_pkg::*;
#(
    parameter  int SAMPLE_W = 12,
    parameter  int LAG      = 32,
    parameter  int HOLD     = 50,
    localparam int ACC_W    = acc_bits(SAMPLE_W, LAG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_re,
    input  logic signed [SAMPLE_W-1:0] in_im,
    output logic                       detect,
    output logic                       locked,
    output logic        [ACC_W-1:0]    corr_mag,
    output logic        [ACC_W-1:0]    energy
);

    localparam int PAIR_W  = 2 * SAMPLE_W;
    localparam int N_LANES = 3;   // correlation real, correlation imag, energy

    // ---------------- lagged sample ----------------
    logic [PAIR_W-1:0]          lag_pair;
    logic signed [SAMPLE_W-1:0] lag_re, lag_im;

    acdet_delay_line #(.W(PAIR_W), .DEPTH(LAG)) u_lag (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (in_valid),
        .clr  (clr),
        .din  ({in_re, in_im}),
        .dout (lag_pair)
    );

    assign lag_re = lag_pair[PAIR_W-1:SAMPLE_W];
    assign lag_im = lag_pair[SAMPLE_W-1:0];

    // ---------------- per-sample terms ----------------
    typedef struct packed {
        logic signed [ACC_W-1:0] xr;
        logic signed [ACC_W-1:0] xi;
        logic signed [ACC_W-1:0] dr;
        logic signed [ACC_W-1:0] di;
    } ext_t;

    ext_t ext;
    logic signed [ACC_W-1:0] lane_in  [N_LANES];
    logic signed [ACC_W-1:0] lane_sum [N_LANES];

    always_comb begin
        ext.xr = ACC_W'(in_re);
        ext.xi = ACC_W'(in_im);
        ext.dr = ACC_W'(lag_re);
        ext.di = ACC_W'(lag_im);
        // current times conjugate of lagged
        lane_in[0] = ext.xr * ext.dr + ext.xi * ext.di;
        lane_in[1] = ext.xi * ext.dr - ext.xr * ext.di;
        // power of lagged
        lane_in[2] = ext.dr * ext.dr + ext.di * ext.di;
    end

    // ---------------- sliding window sums ----------------
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        acdet_window_sum #(.W(ACC_W), .DEPTH(LAG)) u_sum (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (in_valid),
            .clr  (clr),
            .term (lane_in[g]),
            .sum  (lane_sum[g])
        );
    end

    // ---------------- magnitude and threshold ----------------
    typedef struct packed {
        logic [ACC_W-1:0] abs_re;
        logic [ACC_W-1:0] abs_im;
        logic [ACC_W-1:0] mag;
        logic [ACC_W-1:0] pw;
        logic             hit;
    } dec_t;

    dec_t dec;

    always_comb begin
        dec.abs_re = lane_sum[0][ACC_W-1] ? ACC_W'(-lane_sum[0]) : ACC_W'(lane_sum[0]);
        dec.abs_im = lane_sum[1][ACC_W-1] ? ACC_W'(-lane_sum[1]) : ACC_W'(lane_sum[1]);
        dec.mag    = dec.abs_re + dec.abs_im;
        dec.pw     = ACC_W'(lane_sum[2]);
        dec.hit    = dec.mag > (dec.pw >> 1);
    end

    assign corr_mag = dec.mag;
    assign energy   = dec.pw;

    // ---------------- persistence qualifier ----------------
    acdet_hold_qual #(.HOLD(HOLD)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .clr   (clr),
        .hit   (dec.hit),
        .detect(detect),
        .locked(locked)
    );

    // R3
    energy_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_sum[2][ACC_W-1] == 1'b0);

    // R8
    clear_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!locked && !detect && corr_mag == '0));

endmodule

// File: tb/sim_preamble_autocorr_detect.sv
module sim_preamble_autocorr_detect;

    localparam int SW    = 12;
    localparam int LAG   = 32;
    localparam int HOLD  = 50;
    localparam int ACC_W = 2 * SW + 1 + 5;
    localparam int NSC   = 6;

    // scenario table: pattern, amplitude, length, idle gap, expected lock (-1 = any)
    // patterns: 0 periodic, 2 periodic with a negated burst, 3 noise, 4 equal-half ratio
    localparam int SC_PAT [NSC] = '{0, 0, 2, 3, 4, 0};
    localparam int SC_AMP [NSC] = '{300, 2047, 500, 1000, 0, 3};
    localparam int SC_LEN [NSC] = '{120, 120, 260, 150, 64, 120};
    localparam int SC_GAP [NSC] = '{0, 2, 0, 1, 0, 0};
    localparam int SC_LCK [NSC] = '{1, 1, 1, -1, 0, 1};

    logic clk = 0;
    logic rst_n = 0;
    logic clr = 0;
    logic in_valid = 0;
    logic signed [SW-1:0] in_re = '0;
    logic signed [SW-1:0] in_im = '0;
    logic detect, locked;
    logic [ACC_W-1:0] corr_mag, energy;

    always #5 clk = ~clk;

    preamble_autocorr_detect #(.SAMPLE_W(SW), .LAG(LAG), .HOLD(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .detect(detect), .locked(locked),
        .corr_mag(corr_mag), .energy(energy)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    longint hr [0:1023];
    longint hi [0:1023];
    int     m_n;
    longint m_mag, m_pw;
    bit     m_prev_hit, m_lock, m_det;
    int     m_run;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input string tag, input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_n = 0; m_mag = 0; m_pw = 0;
        m_prev_hit = 0; m_lock = 0; m_det = 0; m_run = 0;
    endtask

    task automatic model_push(input longint re, input longint im);
        longint cr, ci, p;
        m_n++;
        hr[m_n] = re; hi[m_n] = im;
        m_run = m_prev_hit ? m_run + 1 : 0;
        cr = 0; ci = 0; p = 0;
        for (int k = 0; k < LAG; k++) begin
            int a = m_n - k;
            int b = a - LAG;
            if (a >= 1 && b >= 1) begin
                cr += hr[a] * hr[b] + hi[a] * hi[b];
                ci += hi[a] * hr[b] - hr[a] * hi[b];
                p  += hr[b] * hr[b] + hi[b] * hi[b];
            end
        end
        m_mag = (cr < 0 ? -cr : cr) + (ci < 0 ? -ci : ci);
        m_pw  = p;
        m_prev_hit = m_mag > (m_pw / 2);
        m_det = (m_run >= HOLD) && !m_lock;
        if (m_det) m_lock = 1;
    endtask

    // one clock: inputs set after a falling edge, outputs compared at the next one
    task automatic step(input bit v, input bit c, input int re, input int im);
        in_valid = v; clr = c;
        in_re = SW'(re); in_im = SW'(im);
        @(posedge clk);
        m_det = 0;
        if (c) model_clear();
        else if (v) model_push(re, im);
        @(negedge clk);
        check("R2/R4/R10 corr_mag", longint'(corr_mag), m_mag);
        check("R3/R10 energy", longint'(energy), m_pw);
        check("R6/R7 detect", longint'(detect), longint'(m_det));
        check("R8 locked", longint'(locked), longint'(m_lock));
    endtask

    function automatic int gen_re(input int pat, input int amp, input int k);
        int j = k % LAG;
        int v = amp * (((j * 7) % 5) - 2) / 2;
        if (pat == 4) return (k < LAG) ? 2 : 1;
        if (pat == 2 && k >= 60 && k <= 75) return -v;
        return v;
    endfunction

    function automatic int gen_im(input int pat, input int amp, input int k);
        int j = k % LAG;
        int v = amp * (((j * 3) % 7) - 3) / 3;
        if (pat == 4) return 0;
        if (pat == 2 && k >= 60 && k <= 75) return -v;
        return v;
    endfunction

    task automatic noise(input int amp, output int re, output int im);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        re = (int'(lfsr[10:0]) - 1024) * amp / 1024;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        im = (int'(lfsr[10:0]) - 1024) * amp / 1024;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [ACC_W-1:0] hold_mag, hold_pw;
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 detect", longint'(detect), 0);
        check("R1 locked", longint'(locked), 0);
        check("R1 corr_mag", longint'(corr_mag), 0);
        check("R1 energy", longint'(energy), 0);
        rst_n = 1;
        @(negedge clk);

        for (int s = 0; s < NSC; s++) begin
            step(0, 1, 0, 0);
            for (int k = 0; k < SC_LEN[s]; k++) begin
                int re, im;
                if (SC_PAT[s] == 3) noise(SC_AMP[s], re, im);
                else begin
                    re = gen_re(SC_PAT[s], SC_AMP[s], k);
                    im = gen_im(SC_PAT[s], SC_AMP[s], k);
                end
                step(1, 0, re, im);
                // R5: equal-half boundary after 64 samples: 64 vs 128
                if (SC_PAT[s] == 4 && k == 63) begin
                    check("R5 corr_mag at half", longint'(corr_mag), 64);
                    check("R5 energy at half", longint'(energy), 128);
                end
                // R9: idle cycles with junk on the sample inputs
                for (int g = 0; g < SC_GAP[s]; g++) step(0, 0, 1234, -777);
            end
            if (SC_LCK[s] >= 0)
                check("R6 scenario lock outcome", longint'(locked), longint'(SC_LCK[s]));
        end

        // R9: directed idle hold after a lock
        step(0, 1, 0, 0);
        for (int k = 0; k < 100; k++) step(1, 0, gen_re(0, 800, k), gen_im(0, 800, k));
        check("R7 locked before idle", longint'(locked), 1);
        hold_mag = corr_mag; hold_pw = energy;
        for (int g = 0; g < 6; g++) step(0, 0, -2048, 2047);
        check("R9 idle corr_mag", longint'(corr_mag), longint'(hold_mag));
        check("R9 idle energy", longint'(energy), longint'(hold_pw));

        // R8: clear wins over a valid sample on the same clock
        step(1, 1, 500, 500);
        check("R8 clear locked", longint'(locked), 0);
        check("R8 clear energy", longint'(energy), 0);
        check("R8 clear corr_mag", longint'(corr_mag), 0);

        // R7: no second pulse while still locked
        for (int k = 0; k < 100; k++) step(1, 0, gen_re(0, 200, k), gen_im(0, 200, k));
        for (int k = 100; k < 180; k++) step(1, 0, gen_re(0, 200, k), gen_im(0, 200, k));

        // R1: asynchronous reset mid-run
        in_valid = 0; clr = 0;
        rst_n = 0;
        #2;
        check("R1 reset locked", longint'(locked), 0);
        check("R1 reset energy", longint'(energy), 0);
        @(negedge clk);
        rst_n = 1;
        model_clear();
        step(1, 0, 100, 0);
        check("R2 first after reset", longint'(corr_mag), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule